// File: doc/BRIEF.md
# Low-Power Mode Controller

This block manages power for a small 8-bit microcontroller core. It uses two independent controls: it can gate the CPU clock (and optionally stop the oscillator), and it can float groups of output pads. A sequence of instructions combines them into six software low-power modes. A separate active-low standby pin gives a hardware power-down that overrides everything else.

Wake-up comes from the active-low interrupt pin, the active-low reset pin, or the release of standby. A wake pin must stay low across a fixed number of address-latch pulses before the core restarts. The wake source and the interrupt context decide the restart request:
- reset: restart at address 0;
- interrupt when enabled: interrupt vector at address 3;
- otherwise: resume at the instruction after the power-down instruction.

After the oscillator has been stopped, a programmable stabilization count keeps the CPU clock off until the oscillator is assumed stable.

Top module: `lp_mode_ctrl`

## Requirements
- R1: After the block's own reset, `cpu_clk_en` and `osc_en` are 1, `float_en` is all zero and `wake_req` is 0.
- R2: `op_halt` while running turns `cpu_clk_en` off from the next cycle and leaves `osc_en` at 1.
- R3: `op_oscstop` while running turns both `cpu_clk_en` and `osc_en` off from the next cycle. `cpu_clk_en` is never 1 while `osc_en` is 0.
- R4: `float_en` bit map: bit0 port 1, bit1 port 2 low nibble, bit2 port 2 high nibble, bit3 data bus, bit4 ALE, bit5 PSEN, bit6 PROG, bit7 RD/WR strobes, bit8 T0 clock output. `op_float` sets `float_en` to 0x00F when `ext_prog`=0 and to 0x005 when `ext_prog`=1, one cycle after the instruction boundary.
- R5: `op_floatall` sets `float_en` to 0x1FF when `ext_prog`=0. When `ext_prog`=1 it sets 0x1C5, so ALE, PSEN, the port 2 low nibble and the bus keep running.
- R6: `float_en` clears on `op_release`, or when `int_n` or `reset_pin_n` is low. While the CPU clock runs, it changes only in a cycle with `instr_boundary`=1.
- R7: A wake pin must stay low across 2 `ale_pulse` samples before `wake_req`. If the pin rises earlier, the block returns to sleep with no request.
- R8: `wake_req` is a one-cycle pulse, and `cpu_clk_en` returns with it. `wake_kind` takes one of three values:
  - 1 (address 3) for an interrupt wake with `int_enable`=1 and `in_isr`=0;
  - 0 (resume) for an interrupt wake with interrupts disabled or inside a service routine;
  - 2 (address 0) for a reset wake.
- R9: A wake from oscillator stop turns `osc_en` on at once. `ale_pulse` is ignored and `cpu_clk_en` stays off for at least `stab_cycles` cycles.
- R10: `standby_n`=0 in any state forces, from the next cycle, `osc_en`=0, `cpu_clk_en`=0 and `float_en`=0x1FF.
- R11: Raising `standby_n` with both wake pins high gives `wake_req` with `wake_kind`=0 after the stabilization count, and never before `stab_cycles` cycles.
- R12: When the reset and interrupt pins are both low at wake, the reset source wins (`wake_kind`=2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (free-running) |
| rst_n | input | 1 | Synchronous active-low block reset |
| op_halt | input | 1 | Decoded clock-halt instruction strobe |
| op_oscstop | input | 1 | Decoded oscillator-stop instruction strobe |
| op_float | input | 1 | Decoded port-float instruction strobe |
| op_floatall | input | 1 | Decoded full-output-float instruction strobe |
| op_release | input | 1 | Decoded float-release instruction strobe |
| instr_boundary | input | 1 | High in the last cycle of an instruction |
| int_n | input | 1 | Interrupt pin, active low |
| reset_pin_n | input | 1 | Reset pin, active low |
| standby_n | input | 1 | Hardware standby pin, active low |
| int_enable | input | 1 | External interrupt enabled in the core |
| in_isr | input | 1 | Core is inside an interrupt routine |
| ext_prog | input | 1 | External program memory mode |
| ale_pulse | input | 1 | One-cycle strobe per address-latch pulse |
| stab_cycles | input | 8 | Oscillator stabilization count |
| cpu_clk_en | output | 1 | CPU control clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| float_en | output | 9 | Per-pin-group float enables (map in R4) |
| wake_req | output | 1 | One-cycle restart request to the sequencer |
| wake_kind | output | 2 | 0 resume, 1 vector 3, 2 vector 0 |

## Verification
Each sleep mode is entered and then woken by a separate source:
- the interrupt pin with interrupts enabled, disabled, and inside a service routine;
- the reset pin, alone and together with the interrupt pin;
- a standby release with both pins high.

Comparing the three interrupt cases separates vectoring from resuming. The two reset cases separate priority from qualification. Address-latch pulses are sent during stabilization and before a pin rises early, which separates a real qualification from a counter that runs freely. The float map is applied in both program-memory modes, and pin-low clears are given without an instruction boundary, which shows both the table and the update gating.

// File: rtl/lp_pkg.sv
// Package: shared state, wake-kind encoding and float-bit indices for the
// low-power controller. Assumes a 9-bit float vector as in the brief.
package lp_pkg;
    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_GATE    = 3'd1,
        ST_OSCOFF  = 3'd2,
        ST_STANDBY = 3'd3,
        ST_STAB    = 3'd4,
        ST_QUAL    = 3'd5,
        ST_WAKE    = 3'd6
    } lp_state_e;

    typedef enum logic [1:0] {
        WK_RESUME = 2'd0,
        WK_VEC3   = 2'd1,
        WK_VEC0   = 2'd2
    } wake_kind_e;

    typedef enum logic [1:0] {
        FL_NONE  = 2'd0,
        FL_PORTS = 2'd1,
        FL_ALL   = 2'd2
    } float_lvl_e;

    localparam int NFLOAT   = 9;
    localparam int FB_P1    = 0;
    localparam int FB_P2LO  = 1;
    localparam int FB_P2HI  = 2;
    localparam int FB_BUS   = 3;
    localparam int FB_ALE   = 4;
    localparam int FB_PSEN  = 5;
    localparam int FB_PROG  = 6;
    localparam int FB_STRB  = 7;
    localparam int FB_T0    = 8;
endpackage

// File: rtl/lp_float_map.sv
// Module: lp_float_map
// Turns a float level, the program-memory mode and the standby flag into
// per-pin-group float enables. Purely combinational. Assumes that in
// external-program mode the fetch path (ALE, PSEN, port 2 low nibble, bus)
// must keep running under software float.
module lp_float_map
    import lp_pkg::*;
(
    input  float_lvl_e              lvl,
    input  logic                    ext_prog,
    input  logic                    standby,
    output logic [NFLOAT-1:0]       fmap
);
    // Table lookup of the float groups for the requested level.
    always_comb begin
        fmap = '0;
        if (standby) begin
            fmap = '1;
        end else begin
            case (lvl)
                FL_PORTS: begin
                    fmap[FB_P1]   = 1'b1;
                    fmap[FB_P2HI] = 1'b1;
                    fmap[FB_P2LO] = !ext_prog;
                    fmap[FB_BUS]  = !ext_prog;
                end
                FL_ALL: begin
                    fmap          = '1;
                    fmap[FB_ALE]  = !ext_prog;
                    fmap[FB_PSEN] = !ext_prog;
                    fmap[FB_P2LO] = !ext_prog;
                    fmap[FB_BUS]  = !ext_prog;
                end
                default: fmap = '0;
            endcase
        end
    end
endmodule

// File: rtl/lp_ale_qual.sv
// Module: lp_ale_qual
// Counts address-latch pulses while a wake pin stays low. Reports
// qualification in the cycle that samples the final required pulse.
// Assumes ale_pulse is a one-cycle strobe; the count clears whenever
// 'active' drops.
module lp_ale_qual #(
    parameter int PULSES = 2,
    localparam int CW = $clog2(PULSES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic ale_pulse,
    output logic done
);
    logic [CW-1:0] cnt_q;

    assign done = active && ale_pulse && (cnt_q == CW'(PULSES - 1));

    // Pulse counter, cleared when the wake pin is not being qualified.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt_q <= '0;
        end else if (ale_pulse && !done) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    a_r7_clear_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt_q == '0));
    a_r7_hold_without_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !ale_pulse && $past(rst_n)) |=> (!active || cnt_q == $past(cnt_q)));
endmodule

// File: rtl/lp_stab_timer.sv
// Module: lp_stab_timer
// Down-counter modelling oscillator settling time. Loaded on entry to the
// settling state, counts while active, expires at zero.
// Assumes 'load' is asserted for one cycle just before 'active' rises.
module lp_stab_timer #(
    parameter int STAB_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              active,
    input  logic [STAB_W-1:0] load_val,
    output logic              expired
);
    logic [STAB_W-1:0] cnt_q;

    assign expired = active && (cnt_q == '0);

    // Load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (active && cnt_q != '0) begin
            cnt_q <= cnt_q - STAB_W'(1);
        end
    end

    a_r9_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - STAB_W'(1)));
endmodule

// File: rtl/lp_mode_ctrl.sv
// Module: lp_mode_ctrl (top)
// Power-mode state machine: clock gating, oscillator stop, hardware
// standby, wake qualification and restart-vector choice, plus registered
// pad float enables. Assumes instruction strobes arrive with
// instr_boundary, and that ext_prog is static while running.
module lp_mode_ctrl
    import lp_pkg::*;
#(
    parameter int STAB_W      = 8,
    parameter int QUAL_PULSES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_halt,
    input  logic              op_oscstop,
    input  logic              op_float,
    input  logic              op_floatall,
    input  logic              op_release,
    input  logic              instr_boundary,
    input  logic              int_n,
    input  logic              reset_pin_n,
    input  logic              standby_n,
    input  logic              int_enable,
    input  logic              in_isr,
    input  logic              ext_prog,
    input  logic              ale_pulse,
    input  logic [STAB_W-1:0] stab_cycles,
    output logic              cpu_clk_en,
    output logic              osc_en,
    output logic [NFLOAT-1:0] float_en,
    output logic              wake_req,
    output logic [1:0]        wake_kind
);
    lp_state_e  state_q, state_d;
    logic       from_sb_q, from_sb_d;
    logic       sleep_osc_q, sleep_osc_d;
    logic       src_rst_q, src_rst_d;
    wake_kind_e kind_q, kind_d;
    float_lvl_e lvl_q, lvl_d;
    logic [NFLOAT-1:0] float_q, fmap;
    logic       pin_low, src_low, qual_done, stab_exp, stab_load, upd_ok;

    assign pin_low = !int_n || !reset_pin_n;
    assign src_low = src_rst_q ? !reset_pin_n : !int_n;

    lp_ale_qual #(.PULSES(QUAL_PULSES)) u_qual (
        .clk(clk), .rst_n(rst_n),
        .active(state_q == ST_QUAL && src_low),
        .ale_pulse(ale_pulse), .done(qual_done)
    );

    assign stab_load = (state_d == ST_STAB) && (state_q != ST_STAB);

    lp_stab_timer #(.STAB_W(STAB_W)) u_stab (
        .clk(clk), .rst_n(rst_n), .load(stab_load),
        .active(state_q == ST_STAB), .load_val(stab_cycles),
        .expired(stab_exp)
    );

    // Next-state and wake bookkeeping for the power-mode machine.
    always_comb begin
        state_d     = state_q;
        from_sb_d   = from_sb_q;
        sleep_osc_d = sleep_osc_q;
        src_rst_d   = src_rst_q;
        kind_d      = kind_q;
        if (!standby_n) begin
            state_d   = ST_STANDBY;
            from_sb_d = 1'b1;
        end else begin
            case (state_q)
                ST_RUN: begin
                    from_sb_d = 1'b0;
                    if (op_oscstop) begin
                        state_d     = ST_OSCOFF;
                        sleep_osc_d = 1'b1;
                    end else if (op_halt) begin
                        state_d     = ST_GATE;
                        sleep_osc_d = 1'b0;
                    end
                end
                ST_GATE: begin
                    if (pin_low) begin
                        state_d   = ST_QUAL;
                        src_rst_d = !reset_pin_n;
                    end
                end
                ST_OSCOFF: begin
                    if (pin_low) state_d = ST_STAB;
                end
                ST_STANDBY: begin
                    state_d = ST_STAB;
                end
                ST_STAB: begin
                    if (stab_exp) begin
                        if (pin_low) begin
                            state_d   = ST_QUAL;
                            src_rst_d = !reset_pin_n;
                        end else if (from_sb_q) begin
                            state_d = ST_WAKE;
                            kind_d  = WK_RESUME;
                        end else begin
                            state_d = ST_OSCOFF;
                        end
                    end
                end
                ST_QUAL: begin
                    if (!src_low) begin
                        if (from_sb_q) begin
                            state_d = ST_WAKE;
                            kind_d  = WK_RESUME;
                        end else begin
                            state_d = sleep_osc_q ? ST_OSCOFF : ST_GATE;
                        end
                    end else if (qual_done) begin
                        state_d = ST_WAKE;
                        if (src_rst_q)                  kind_d = WK_VEC0;
                        else if (int_enable && !in_isr) kind_d = WK_VEC3;
                        else                            kind_d = WK_RESUME;
                    end
                end
                ST_WAKE: state_d = ST_RUN;
                default: state_d = ST_RUN;
            endcase
        end
    end

    // Next float level: pin-low release beats instructions.
    always_comb begin
        lvl_d = lvl_q;
        if (pin_low)                          lvl_d = FL_NONE;
        else if (state_q == ST_RUN) begin
            if (op_release)                   lvl_d = FL_NONE;
            else if (op_floatall)             lvl_d = FL_ALL;
            else if (op_float)                lvl_d = FL_PORTS;
        end
    end

    assign upd_ok = instr_boundary || (state_q != ST_RUN) || (state_d != ST_RUN);

    lp_float_map u_map (
        .lvl(lvl_d), .ext_prog(ext_prog),
        .standby(state_d == ST_STANDBY), .fmap(fmap)
    );

    // State and bookkeeping registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_RUN;
            from_sb_q   <= 1'b0;
            sleep_osc_q <= 1'b0;
            src_rst_q   <= 1'b0;
            kind_q      <= WK_RESUME;
        end else begin
            state_q     <= state_d;
            from_sb_q   <= from_sb_d;
            sleep_osc_q <= sleep_osc_d;
            src_rst_q   <= src_rst_d;
            kind_q      <= kind_d;
        end
    end

    // Float level and registered float enables, updated only when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= FL_NONE;
            float_q <= '0;
        end else if (upd_ok) begin
            lvl_q   <= lvl_d;
            float_q <= fmap;
        end
    end

    assign cpu_clk_en = (state_q == ST_RUN) || (state_q == ST_WAKE);
    assign osc_en     = (state_q != ST_OSCOFF) && (state_q != ST_STANDBY);
    assign float_en   = float_q;
    assign wake_req   = (state_q == ST_WAKE);
    assign wake_kind  = kind_q;

    a_r3_no_clk_without_osc: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !cpu_clk_en);
    a_r8_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req);
    a_r10_standby_forces: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_n |=> (!osc_en && !cpu_clk_en && (&float_en)));
    a_r6_float_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !instr_boundary && standby_n && !op_halt && !op_oscstop)
        |=> $stable(float_en));
    a_r12_reset_vector_src: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && wake_kind == 2'd2 && $past(rst_n)) |-> $past(!reset_pin_n));
endmodule

// File: tb/lp_mode_ctrl_tb.sv
module lp_mode_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n;
    logic op_halt, op_oscstop, op_float, op_floatall, op_release, instr_boundary;
    logic int_n, reset_pin_n, standby_n, int_enable, in_isr, ext_prog, ale_pulse;
    logic [7:0] stab_cycles;
    logic cpu_clk_en, osc_en, wake_req;
    logic [8:0] float_en;
    logic [1:0] wake_kind;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lp_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .op_halt(op_halt), .op_oscstop(op_oscstop),
        .op_float(op_float), .op_floatall(op_floatall), .op_release(op_release),
        .instr_boundary(instr_boundary), .int_n(int_n), .reset_pin_n(reset_pin_n),
        .standby_n(standby_n), .int_enable(int_enable), .in_isr(in_isr),
        .ext_prog(ext_prog), .ale_pulse(ale_pulse), .stab_cycles(stab_cycles),
        .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .float_en(float_en),
        .wake_req(wake_req), .wake_kind(wake_kind)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One-cycle instruction strobe at a boundary.
    task automatic issue(input int which);
        instr_boundary = 1'b1;
        case (which)
            0: op_halt = 1'b1;
            1: op_oscstop = 1'b1;
            2: op_float = 1'b1;
            3: op_floatall = 1'b1;
            default: op_release = 1'b1;
        endcase
        step(1);
        {op_halt, op_oscstop, op_float, op_floatall, op_release, instr_boundary} = '0;
    endtask

    // Send n ALE strobes back to back; returns wake_req after the last.
    task automatic ale(input int n, output logic wr);
        for (int i = 0; i < n; i++) begin
            ale_pulse = 1'b1;
            step(1);
            ale_pulse = 1'b0;
        end
        wr = wake_req;
    endtask

    task automatic t_reset();
        check("R1 clk_en", cpu_clk_en, 1);
        check("R1 osc_en", osc_en, 1);
        check("R1 float_en", float_en, 0);
        check("R1 wake_req", wake_req, 0);
    endtask

    task automatic t_halt_int(input logic en, input logic isr, input int exp_kind, input string tag);
        logic wr;
        int_enable = en; in_isr = isr;
        issue(0);
        check("R2 clk gated", cpu_clk_en, 0);
        check("R2 osc kept", osc_en, 1);
        int_n = 1'b0;
        step(1);
        ale(1, wr);
        check("R7 no wake after one pulse", wr, 0);
        ale(1, wr);
        check({tag, " wake_req"}, wr, 1);
        check({tag, " wake_kind"}, wake_kind, exp_kind);
        check("R8 clock back", cpu_clk_en, 1);
        int_n = 1'b1;
        step(1);
        check("R8 single pulse", wake_req, 0);
    endtask

    task automatic t_early_release();
        logic wr;
        issue(0);
        int_n = 1'b0;
        step(1);
        ale(1, wr);
        int_n = 1'b1;
        step(2);
        ale(2, wr);
        check("R7 early release no wake", wr, 0);
        check("R7 still gated", cpu_clk_en, 0);
        // R12: both pins low, reset wins
        int_n = 1'b0; reset_pin_n = 1'b0;
        step(1);
        ale(2, wr);
        check("R12 wake_req", wr, 1);
        check("R12 kind vector0", wake_kind, 2);
        int_n = 1'b1; reset_pin_n = 1'b1;
        step(2);
    endtask

    task automatic t_oscstop();
        logic wr;
        int_enable = 1'b1; in_isr = 1'b0;
        issue(1);
        check("R3 clk off", cpu_clk_en, 0);
        check("R3 osc off", osc_en, 0);
        int_n = 1'b0;
        step(1);
        check("R9 osc on at once", osc_en, 1);
        ale(2, wr);
        check("R9 ale ignored while settling", wr, 0);
        check("R9 clk held", cpu_clk_en, 0);
        step(10);
        ale(2, wr);
        check("R9 wake after settling", wr, 1);
        check("R9 kind vector3", wake_kind, 1);
        int_n = 1'b1;
        step(2);
    endtask

    task automatic t_float();
        ext_prog = 1'b0;
        issue(2);
        check("R4 port float int", float_en, 9'h00F);
        issue(4);
        check("R6 release", float_en, 0);
        ext_prog = 1'b1;
        issue(2);
        check("R4 port float ext", float_en, 9'h005);
        issue(3);
        check("R5 full float ext", float_en, 9'h1C5);
        ext_prog = 1'b0;
        issue(3);
        check("R5 full float int", float_en, 9'h1FF);
        int_n = 1'b0;
        step(2);
        check("R6 no change off boundary", float_en, 9'h1FF);
        instr_boundary = 1'b1;
        step(1);
        instr_boundary = 1'b0;
        int_n = 1'b1;
        check("R6 int clears at boundary", float_en, 0);
        step(1);
    endtask

    task automatic t_standby();
        int cyc = 0;
        int got = 0;
        int kind = -1;
        issue(2);
        standby_n = 1'b0;
        step(1);
        check("R10 osc off", osc_en, 0);
        check("R10 clk off", cpu_clk_en, 0);
        check("R10 all float", float_en, 9'h1FF);
        step(3);
        standby_n = 1'b1;
        for (int i = 0; i < 60 && got == 0; i++) begin
            step(1);
            cyc++;
            if (wake_req) begin got = 1; kind = wake_kind; end
        end
        check("R11 wake seen", got, 1);
        check("R11 kind resume", kind, 0);
        check("R11 not before settle", int'(cyc > int'(stab_cycles)), 1);
        step(1);
        check("R11 running", cpu_clk_en, 1);
    endtask

    initial begin
        rst_n = 1'b0;
        {op_halt, op_oscstop, op_float, op_floatall, op_release, instr_boundary} = '0;
        int_n = 1'b1; reset_pin_n = 1'b1; standby_n = 1'b1;
        int_enable = 1'b0; in_isr = 1'b0; ext_prog = 1'b0; ale_pulse = 1'b0;
        stab_cycles = 8'd5;
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_halt_int(1'b1, 1'b0, 1, "R8 int enabled");
        t_halt_int(1'b0, 1'b0, 0, "R8 int disabled");
        t_halt_int(1'b1, 1'b1, 0, "R8 in isr");
        t_early_release();
        t_oscstop();
        t_float();
        t_standby();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule